// File: doc/BRIEF.md
# Quad Wiper Setting Register Target on a Two-Wire Bus

This block is the serial-bus side of a four-channel digital potentiometer. It watches an I2C bus through a pair of synchronised inputs and takes part in it as a target. The upper five bits of its 7-bit address are fixed. The lower two bits come from strap inputs, so up to four of these blocks can share one bus. Its state is four wiper setting registers. Their values are driven out in parallel to the resistor ladders.

A write transfer carries the address byte, then an instruction byte, then any number of data bytes. The instruction byte holds a command flag, a volatile/non-volatile select and a 5-bit register pointer. Each data byte goes to the register at the pointer, and the pointer then steps to the next register. Pointer values above the last wiper are reserved: data sent to them is acknowledged and dropped. Instructions that ask for command mode or for the non-volatile store are acknowledged and raise a status flag, but no data reaches the wipers while that instruction is in force. A read transfer returns the register at the current pointer, one byte after another, for as long as the controller acknowledges.

Top module: `quad_wiper_i2c_target`

## Requirements
- R1: After reset, every wiper output is mid-scale 0x80, `cmd_flag` is low and `sda_oe` is low (SDA released).
- R2: A START is SDA falling while SCL is high. When the address byte after it has bits 7:1 equal to 0101_1 followed by `strap_in[1]` and `strap_in[0]`, the target acknowledges by asserting `sda_oe` through the ninth SCL high phase. Bit 0 of the address byte selects write (0) or read (1).
- R3: An address byte that does not match gets no acknowledge. Every later byte up to the next START is ignored: no acknowledge and no register change.
- R4: In the instruction byte, bit 7 selects command (1) or register access (0), bit 6 selects non-volatile (1) or volatile (0), and bits 4:0 load the register pointer. The instruction byte is always acknowledged.
- R5: After a volatile register-access instruction, each data byte is acknowledged and written to wiper number `pointer` when the pointer is 0 to 3. Wiper n appears on `wiper_o[8n+7:8n]`.
- R6: The pointer increments by one after every data byte, so consecutive data bytes fill consecutive wipers.
- R7: Data bytes sent while the pointer is 4 to 31 (reserved) are acknowledged and change no wiper. The pointer wraps from 31 to 0.
- R8: An instruction with bit 7 or bit 6 set raises `cmd_flag`. The data bytes that follow it are acknowledged and change no wiper.
- R9: `cmd_flag` stays high until an instruction with bits 7 and 6 both 0 is received, which clears it.
- R10: After a matching address with bit 0 = 1, the target sends the wiper at the pointer, MSB first, with reserved pointers reading 0x00. The pointer advances when the controller acknowledges a byte. A not-acknowledge ends the transfer.
- R11: A STOP (SDA rising while SCL high) or a repeated START in the middle of a byte abandons that byte without writing it. A repeated START returns the target to address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL level as seen on the bus |
| sda_in | input | 1 | SDA level as seen on the bus |
| strap_in | input | 2 | Address straps; bit 1 and bit 0 are the two low address bits |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| cmd_flag | output | 1 | Set by a command or non-volatile instruction |
| wiper_o | output | NUM_WIPERS*WIPER_W | Wiper settings, wiper n in bits [8n+7:8n] |

## Verification
The bench builds the block with its default parameters: four 8-bit wipers, the fixed 01011 address prefix and a reset value of 0x80. With four wipers, a 5-bit pointer reaches 28 reserved slots. The bench uses this for the 3-to-4 overrun, the 31-to-0 wrap and reads of a reserved slot. The straps are switched during the run, so the same address byte is accepted in one phase and refused in another. The SCL period is 20 system clocks, which leaves room to sample the acknowledge and the read bits well inside each SCL phase.

// File: rtl/wiper_i2c_pkg.sv
package wiper_i2c_pkg;

  // Width of a bus byte and of the register pointer carried in the instruction byte
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_INSTR,
    ST_WDATA,
    ST_RDATA
  } xfer_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_m, sda_m;
  logic scl_s, scl_q, sda_q;

  // Two synchroniser stages plus one history stage; the bus idles high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1;
      sda_m <= 1'b1;
      scl_s <= 1'b1;
      sda_s <= 1'b1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_m <= scl_in;
      sda_m <= sda_in;
      scl_s <= scl_m;
      sda_s <= sda_m;
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise  = scl_s & ~scl_q;
    scl_fall  = ~scl_s & scl_q;
    start_det = scl_s & scl_q & sda_q & ~sda_s;
    stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  end

endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
  import wiper_i2c_pkg::*;
#(
  parameter int NUM_WIPERS = 4,
  parameter int WIPER_W    = 8,
  parameter int RST_VAL    = 128
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [PTR_W-1:0]              wr_addr,
  input  logic [WIPER_W-1:0]            wr_data,
  input  logic [PTR_W-1:0]              rd_addr,
  output logic [WIPER_W-1:0]            rd_data,
  output logic [NUM_WIPERS*WIPER_W-1:0] wiper_o
);

  localparam logic [WIPER_W-1:0] RST_WORD = WIPER_W'(RST_VAL);

  for (genvar g = 0; g < NUM_WIPERS; g++) begin : g_lane
    logic              lane_we;
    logic [WIPER_W-1:0] val_q;

    assign lane_we = wr_en && (wr_addr == PTR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= RST_WORD;
      end else if (lane_we) begin
        val_q <= wr_data;
      end
    end

    assign wiper_o[g*WIPER_W +: WIPER_W] = val_q;
  end

  // Reserved pointer values read back as zero
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_WIPERS; i++) begin
      if (rd_addr == PTR_W'(i)) rd_data = wiper_o[i*WIPER_W +: WIPER_W];
    end
  end

endmodule

// File: rtl/i2c_wiper_fsm.sv
module i2c_wiper_fsm
  import wiper_i2c_pkg::*;
#(
  parameter int           WIPER_W = 8,
  parameter logic [4:0]   ADDR_HI = 5'b01011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [1:0]         strap_in,
  input  logic [WIPER_W-1:0] rd_data,
  output logic               sda_oe,
  output logic               cmd_flag,
  output logic               wr_en,
  output logic [PTR_W-1:0]   wr_addr,
  output logic [WIPER_W-1:0] wr_data,
  output logic [PTR_W-1:0]   rd_addr
);

  xfer_state_e        state_q, state_d, nxt_q, nxt_d;
  logic [3:0]         bitcnt_q, bitcnt_d;
  logic               ack_q, ack_d;
  logic [BYTE_W-1:0]  shreg_q, shreg_d;
  logic               oe_q, oe_d;
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic               regok_q, regok_d;
  logic               flag_q, flag_d;
  logic               mack_q, mack_d;
  logic [BYTE_W-1:0]  rd_byte;

  assign rd_byte = BYTE_W'(rd_data);
  // During the controller's acknowledge slot the next byte is fetched ahead
  assign rd_addr = (state_q == ST_RDATA && ack_q) ? ptr_q + 1'b1 : ptr_q;
  assign wr_addr = ptr_q;
  assign wr_data = shreg_q[WIPER_W-1:0];
  assign sda_oe  = oe_q;
  assign cmd_flag = flag_q;

  always_comb begin
    state_d  = state_q;
    nxt_d    = nxt_q;
    bitcnt_d = bitcnt_q;
    ack_d    = ack_q;
    shreg_d  = shreg_q;
    oe_d     = oe_q;
    ptr_d    = ptr_q;
    regok_d  = regok_q;
    flag_d   = flag_q;
    mack_d   = mack_q;
    wr_en    = 1'b0;

    if (start_det) begin
      state_d  = ST_ADDR;
      bitcnt_d = '0;
      ack_d    = 1'b0;
      oe_d     = 1'b0;
    end else if (stop_det) begin
      state_d  = ST_IDLE;
      bitcnt_d = '0;
      ack_d    = 1'b0;
      oe_d     = 1'b0;
    end else if (state_q != ST_IDLE) begin
      if (ack_q && state_q == ST_RDATA) begin
        // Controller acknowledge slot after a read byte
        if (scl_rise) mack_d = ~sda_s;
        if (scl_fall) begin
          ack_d    = 1'b0;
          bitcnt_d = '0;
          if (mack_q) begin
            ptr_d   = ptr_q + 1'b1;
            shreg_d = rd_byte;
            oe_d    = ~rd_byte[BYTE_W-1];
          end else begin
            state_d = ST_IDLE;
          end
        end
      end else if (ack_q) begin
        // Target acknowledge slot ends on the ninth falling edge
        if (scl_fall) begin
          ack_d    = 1'b0;
          oe_d     = 1'b0;
          bitcnt_d = '0;
          state_d  = nxt_q;
          if (nxt_q == ST_RDATA) begin
            shreg_d = rd_byte;
            oe_d    = ~rd_byte[BYTE_W-1];
          end
        end
      end else if (state_q == ST_RDATA) begin
        if (scl_rise) bitcnt_d = bitcnt_q + 1'b1;
        if (scl_fall) begin
          if (bitcnt_q == 4'd8) begin
            oe_d     = 1'b0;
            ack_d    = 1'b1;
            mack_d   = 1'b0;
            bitcnt_d = '0;
          end else begin
            shreg_d = {shreg_q[BYTE_W-2:0], 1'b0};
            oe_d    = ~shreg_q[BYTE_W-2];
          end
        end
      end else begin
        if (scl_rise) begin
          shreg_d  = {shreg_q[BYTE_W-2:0], sda_s};
          bitcnt_d = bitcnt_q + 1'b1;
        end
        if (scl_fall && bitcnt_q == 4'd8) begin
          bitcnt_d = '0;
          unique case (state_q)
            ST_ADDR: begin
              if (shreg_q[7:1] == {ADDR_HI, strap_in}) begin
                oe_d  = 1'b1;
                ack_d = 1'b1;
                nxt_d = shreg_q[0] ? ST_RDATA : ST_INSTR;
              end else begin
                state_d = ST_IDLE;
              end
            end
            ST_INSTR: begin
              oe_d    = 1'b1;
              ack_d   = 1'b1;
              ptr_d   = shreg_q[PTR_W-1:0];
              regok_d = ~shreg_q[7] & ~shreg_q[6];
              flag_d  = shreg_q[7] | shreg_q[6];
              nxt_d   = ST_WDATA;
            end
            ST_WDATA: begin
              oe_d  = 1'b1;
              ack_d = 1'b1;
              wr_en = regok_q;
              ptr_d = ptr_q + 1'b1;
              nxt_d = ST_WDATA;
            end
            default: begin
              state_d = ST_IDLE;
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      nxt_q    <= ST_IDLE;
      bitcnt_q <= '0;
      ack_q    <= 1'b0;
      shreg_q  <= '0;
      oe_q     <= 1'b0;
      ptr_q    <= '0;
      regok_q  <= 1'b0;
      flag_q   <= 1'b0;
      mack_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      nxt_q    <= nxt_d;
      bitcnt_q <= bitcnt_d;
      ack_q    <= ack_d;
      shreg_q  <= shreg_d;
      oe_q     <= oe_d;
      ptr_q    <= ptr_d;
      regok_q  <= regok_d;
      flag_q   <= flag_d;
      mack_q   <= mack_d;
    end
  end

endmodule

// File: rtl/quad_wiper_i2c_target.sv
module quad_wiper_i2c_target
  import wiper_i2c_pkg::*;
#(
  parameter int         NUM_WIPERS = 4,
  parameter int         WIPER_W    = 8,
  parameter logic [4:0] ADDR_HI    = 5'b01011,
  parameter int         RST_VAL    = 128
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          scl_in,
  input  logic                          sda_in,
  input  logic [1:0]                    strap_in,
  output logic                          sda_oe,
  output logic                          cmd_flag,
  output logic [NUM_WIPERS*WIPER_W-1:0] wiper_o
);

  logic rst_meta, rst_sync;
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [PTR_W-1:0]   wr_addr, rd_addr;
  logic [WIPER_W-1:0] wr_data, rd_data;

  // Assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  i2c_line_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_sync),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_wiper_fsm #(
    .WIPER_W (WIPER_W),
    .ADDR_HI (ADDR_HI)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .strap_in  (strap_in),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .cmd_flag  (cmd_flag),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr)
  );

  wiper_bank #(
    .NUM_WIPERS (NUM_WIPERS),
    .WIPER_W    (WIPER_W),
    .RST_VAL    (RST_VAL)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wiper_o (wiper_o)
  );

endmodule

// File: rtl/quad_wiper_i2c_chk.sv
module quad_wiper_i2c_chk
  import wiper_i2c_pkg::*;
#(
  parameter int NUM_WIPERS = 4,
  parameter int WIPER_W    = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          scl_in,
  input logic                          sda_oe,
  input logic                          cmd_flag,
  input logic [NUM_WIPERS*WIPER_W-1:0] wiper_o,
  input logic                          wr_en,
  input logic [PTR_W-1:0]              wr_addr
);

  for (genvar g = 0; g < NUM_WIPERS; g++) begin : g_lane_chk
    // R5
    lane_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wiper_o[g*WIPER_W +: WIPER_W]) |-> ($past(wr_en) && $past(wr_addr) == PTR_W'(g)));
  end

  // R7
  reserved_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= PTR_W'(NUM_WIPERS)) |=> $stable(wiper_o));

  // R2
  ack_drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_in);

  // R8
  flag_change_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_flag) |-> !scl_in);

endmodule

bind quad_wiper_i2c_target quad_wiper_i2c_chk #(
  .NUM_WIPERS (NUM_WIPERS),
  .WIPER_W    (WIPER_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_in   (scl_in),
  .sda_oe   (sda_oe),
  .cmd_flag (cmd_flag),
  .wiper_o  (wiper_o),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr)
);

// File: tb/quad_wiper_i2c_target_tb_top.sv
`timescale 1ns/1ps
module quad_wiper_i2c_target_tb_top;

  localparam int Q = 5;          // quarter SCL period in system clocks
  localparam int K_NONE  = 0;
  localparam int K_INSTR = 1;
  localparam int K_DATA  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_oe, cmd_flag;
  logic [31:0] wiper_o;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  quad_wiper_i2c_target dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_m),
    .sda_in   (sda_bus),
    .strap_in (strap),
    .sda_oe   (sda_oe),
    .cmd_flag (cmd_flag),
    .wiper_o  (wiper_o)
  );

  // Behavioural reference state
  logic [7:0] exp_w [4];
  int  exp_ptr;
  bit  exp_ok;
  bit  exp_flag;
  int  settle;
  bit  cmp_on;
  int  checks;
  int  failures;
  bit  done;

  function automatic logic [31:0] exp_vec();
    return {exp_w[3], exp_w[2], exp_w[1], exp_w[0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison of the parallel outputs against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      if (settle > 0) settle--;
      else begin
        chk(wiper_o == exp_vec(), "R5 wiper outputs", wiper_o, exp_vec());
        chk(cmd_flag == exp_flag, "R9 cmd_flag", 32'(cmd_flag), 32'(exp_flag));
      end
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_apply(input int kind, input logic [7:0] b);
    settle = 6;
    if (kind == K_INSTR) begin
      exp_ptr  = int'(b[4:0]);
      exp_ok   = (b[7:6] == 2'b00);
      exp_flag = b[7] | b[6];
    end else if (kind == K_DATA) begin
      if (exp_ok && exp_ptr < 4) exp_w[exp_ptr] = b;
      exp_ptr = (exp_ptr + 1) % 32;
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(2*Q);
      scl_m = 1'b0; wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input int kind, input string req);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(2*Q);
      scl_m = 1'b0;
      if (i == 0) model_apply(kind, b);
      wq(Q);
    end
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    chk(sda_oe == exp_ack, req, 32'(sda_oe), 32'(exp_ack));
    wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input bit m_ack, input string req);
    logic [7:0] got;
    logic [7:0] exp;
    exp = (exp_ptr < 4) ? exp_w[exp_ptr] : 8'h00;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q);
      got[i] = sda_bus; wq(Q);
      scl_m = 1'b0; wq(Q);
    end
    chk(got == exp, req, 32'(got), 32'(exp));
    sda_m = ~m_ack; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    scl_m = 1'b0;
    if (m_ack) exp_ptr = (exp_ptr + 1) % 32;
    wq(Q);
    sda_m = 1'b1;
  endtask

  // Address bytes for the straps in use
  function automatic logic [7:0] addr_byte(input logic [1:0] s, input bit rd);
    return {5'b01011, s, rd};
  endfunction

  initial begin
    checks = 0; failures = 0; done = 0; cmp_on = 0; settle = 0;
    for (int i = 0; i < 4; i++) exp_w[i] = 8'h80;
    exp_ptr = 0; exp_ok = 0; exp_flag = 0;
    wq(5);
    // R1 reset state
    chk(wiper_o == 32'h80808080, "R1 reset wipers", wiper_o, 32'h80808080);
    chk(cmd_flag == 1'b0, "R1 reset flag", 32'(cmd_flag), 0);
    chk(sda_oe == 1'b0, "R1 reset sda_oe", 32'(sda_oe), 0);
    rst_n = 1'b1;
    wq(5);
    cmp_on = 1;

    // R2 R5 single write to wiper 2
    bus_start();
    send_byte(addr_byte(2'b10, 0), 1, K_NONE, "R2 address ack");
    send_byte(8'h02, 1, K_INSTR, "R4 instruction ack");
    send_byte(8'h3C, 1, K_DATA, "R5 data ack");
    bus_stop();

    // R3 mismatched straps and foreign address
    bus_start();
    send_byte(addr_byte(2'b01, 0), 0, K_NONE, "R3 strap mismatch nack");
    send_byte(8'h00, 0, K_NONE, "R3 ignored instruction");
    send_byte(8'h11, 0, K_NONE, "R3 ignored data");
    bus_stop();
    bus_start();
    send_byte(8'hA0, 0, K_NONE, "R3 foreign address nack");
    bus_stop();

    // R6 R7 consecutive write from wiper 1 into reserved slot 4
    bus_start();
    send_byte(addr_byte(2'b10, 0), 1, K_NONE, "R2 address ack");
    send_byte(8'h01, 1, K_INSTR, "R4 instruction ack");
    send_byte(8'h10, 1, K_DATA, "R6 data ack wiper1");
    send_byte(8'h20, 1, K_DATA, "R6 data ack wiper2");
    send_byte(8'h30, 1, K_DATA, "R6 data ack wiper3");
    send_byte(8'h40, 1, K_DATA, "R7 reserved data ack");
    bus_stop();

    // R7 pointer wrap 31 -> 0
    bus_start();
    send_byte(addr_byte(2'b10, 0), 1, K_NONE, "R2 address ack");
    send_byte(8'h1F, 1, K_INSTR, "R4 instruction ack");
    send_byte(8'hAA, 1, K_DATA, "R7 reserved 31 ack");
    send_byte(8'h55, 1, K_DATA, "R7 wrapped write ack");
    bus_stop();

    // R8 command and non-volatile instructions
    bus_start();
    send_byte(addr_byte(2'b10, 0), 1, K_NONE, "R2 address ack");
    send_byte(8'h80, 1, K_INSTR, "R8 command instruction ack");
    send_byte(8'h99, 1, K_DATA, "R8 data after command ack");
    bus_stop();
    chk(cmd_flag == 1'b1, "R8 flag after command", 32'(cmd_flag), 1);
    bus_start();
    send_byte(addr_byte(2'b10, 0), 1, K_NONE, "R2 address ack");
    send_byte(8'h41, 1, K_INSTR, "R8 non-volatile instruction ack");
    send_byte(8'h66, 1, K_DATA, "R8 data after non-volatile ack");
    bus_stop();
    chk(wiper_o == exp_vec(), "R8 wipers untouched", wiper_o, exp_vec());

    // R9 register-access instruction clears the flag
    bus_start();
    send_byte(addr_byte(2'b10, 0), 1, K_NONE, "R2 address ack");
    send_byte(8'h03, 1, K_INSTR, "R9 instruction ack");
    send_byte(8'hC3, 1, K_DATA, "R9 data ack");
    bus_stop();
    chk(cmd_flag == 1'b0, "R9 flag cleared", 32'(cmd_flag), 0);

    // R10 R11 read through a repeated START, ending on a reserved slot
    bus_start();
    send_byte(addr_byte(2'b10, 0), 1, K_NONE, "R2 address ack");
    send_byte(8'h02, 1, K_INSTR, "R4 instruction ack");
    bus_start();
    send_byte(addr_byte(2'b10, 1), 1, K_NONE, "R11 address after repeated start");
    recv_byte(1, "R10 read wiper2");
    recv_byte(1, "R10 read wiper3");
    recv_byte(0, "R10 read reserved zero");
    bus_stop();

    // R2 straps changed: the other address now answers
    strap = 2'b01;
    wq(4);
    bus_start();
    send_byte(addr_byte(2'b10, 0), 0, K_NONE, "R3 old address now nack");
    bus_stop();
    bus_start();
    send_byte(addr_byte(2'b01, 0), 1, K_NONE, "R2 new strap ack");
    send_byte(8'h00, 1, K_INSTR, "R4 instruction ack");
    send_byte(8'h01, 1, K_DATA, "R5 data ack wiper0");
    bus_stop();

    // R11 STOP in the middle of a data byte
    bus_start();
    send_byte(addr_byte(2'b01, 0), 1, K_NONE, "R2 address ack");
    send_byte(8'h00, 1, K_INSTR, "R4 instruction ack");
    send_bits(8'hF0, 4);
    bus_stop();
    chk(wiper_o[7:0] == 8'h01, "R11 stop abandons byte", 32'(wiper_o[7:0]), 32'h01);

    // R11 repeated START in the middle of a data byte
    bus_start();
    send_byte(addr_byte(2'b01, 0), 1, K_NONE, "R2 address ack");
    send_byte(8'h01, 1, K_INSTR, "R4 instruction ack");
    send_bits(8'h0F, 5);
    bus_start();
    send_byte(addr_byte(2'b01, 0), 1, K_NONE, "R11 address after restart");
    send_byte(8'h01, 1, K_INSTR, "R4 instruction ack");
    send_byte(8'h77, 1, K_DATA, "R11 data after restart");
    bus_stop();
    wq(8);
    chk(wiper_o[15:8] == 8'h77, "R11 write after restart", 32'(wiper_o[15:8]), 32'h77);

    cmp_on = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule